// File: doc/BRIEF.md
# Single-Clock FIFO with Optional Fall-Through

This block is a parameterised first-in first-out buffer for one clock domain. A producer offers data with a valid/ready handshake on the write side, and a consumer takes data with a valid/ready handshake on the read side. An occupancy count from zero to the configured depth is always visible. Read and write pointers each carry an extra wrap bit, so a full buffer and an empty buffer can be told apart without a separate flag.

A compile-time switch selects fall-through behaviour. With the switch on, an empty FIFO shows the incoming write word at its read port in the same cycle. If the consumer accepts that word in that cycle, it passes straight through and is never stored. With the switch off, a word becomes visible one cycle after it is written.

For exactly one cycle after reset is released, an internal settling flag holds both read-valid and write-ready low, so neither handshake can complete in that cycle.

Top module: `sync_fifo_pt`

## Requirements
- R1: While reset is asserted and after it, before any write, cnt_o is 0 and rvalid_o is 0.
- R2: In the first clock cycle after rst_ni is released, rvalid_o and wready_o are both 0, whatever wvalid_i is; in every later cycle this flag has no effect.
- R3: wready_o is 0 whenever cnt_o equals DEPTH.
- R4: With PASS_THRU = 0, rvalid_o is 1 only when cnt_o is nonzero, so a word written to an empty FIFO appears on the read side one cycle later.
- R5: Words leave the read port in the order they were accepted, across pointer wrap-around.
- R6: With PASS_THRU = 1 and the FIFO empty, rvalid_o equals wvalid_i (outside the settling cycle) and rdata_o equals wdata_i.
- R7: With PASS_THRU = 1, an empty FIFO that completes a write and a read handshake in the same cycle stays empty (cnt_o stays 0).
- R8: A write and a read handshake in the same cycle on a FIFO that is neither empty nor full leave cnt_o unchanged.
- R9: cnt_o rises by one for each stored write and falls by one for each read, and never exceeds DEPTH.
- R10: A write offered while wready_o is 0 is dropped: the stored contents and the count are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wvalid_i | input | 1 | Write data offered |
| wready_o | output | 1 | FIFO can accept a write |
| wdata_i | input | WIDTH | Write data |
| rvalid_o | output | 1 | Read data available |
| rready_i | input | 1 | Consumer takes the read data |
| rdata_o | output | WIDTH | Read data |
| cnt_o | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The embedded assertions check on every cycle that the settling cycle blocks both handshakes and that a full FIFO refuses writes. They also check that the count stays within range, that a concurrent push and pop keeps the count, and that the fall-through path both forwards the write word and stores nothing. Data ordering across pointer wrap, the one-cycle delay in the non-fall-through variant, and the survival of stored contents when a write to a full FIFO is dropped can only be shown by the bench's scenarios. These scenarios compare the words read out against the words written in.

// File: rtl/sync_fifo_pkg.sv
package sync_fifo_pkg;
  // Address width for a given depth; at least one bit.
  function automatic int addr_w(int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wrap_q <= 1'b0;
    end else if (inc_i) begin
      if (addr_q == LAST) begin
        addr_q <= '0;
        wrap_q <= ~wrap_q;
      end else begin
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  assign addr_o = addr_q;
  assign wrap_o = wrap_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST); // R9
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = mem_q[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (raddr_i == AW'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/fifo_status.sv
module fifo_status #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CW    = 3
) (
  input  logic [AW-1:0] waddr_i,
  input  logic          wwrap_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          rwrap_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic same_addr;
  assign same_addr = (waddr_i == raddr_i);
  assign empty_o   = same_addr && (wwrap_i == rwrap_i);
  assign full_o    = same_addr && (wwrap_i != rwrap_i);

  always_comb begin
    if (wwrap_i == rwrap_i) cnt_o = CW'(waddr_i) - CW'(raddr_i);
    else                    cnt_o = CW'(DEPTH) - CW'(raddr_i) + CW'(waddr_i);
  end
endmodule

// File: rtl/sync_fifo_pt.sv
module sync_fifo_pt
  import sync_fifo_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 4,
  parameter bit PASS_THRU = 1'b1,
  localparam int AW = addr_w(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wvalid_i,
  output logic             wready_o,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    cnt_o
);
  logic          settle_q;
  logic          push, pop, empty, full;
  logic [AW-1:0] waddr, raddr;
  logic          wwrap, rwrap;
  logic [WIDTH-1:0] mem_rdata;

  // High only in the first cycle after reset release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) settle_q <= 1'b1;
    else         settle_q <= 1'b0;
  end

  assign wready_o = !full && !settle_q;

  if (PASS_THRU) begin : g_pass
    logic bypass;
    assign rvalid_o = (!empty || wvalid_i) && !settle_q;
    assign rdata_o  = empty ? wdata_i : mem_rdata;
    assign bypass   = empty && rready_i;
    assign push     = wvalid_i && wready_o && !bypass;
    assign pop      = rvalid_o && rready_i && !empty;

    AST_FALLTHRU_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty && rvalid_o) |-> (rdata_o == wdata_i)); // R6
    AST_FALLTHRU_NOSTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o == '0 && wvalid_i && wready_o && rready_i) |=> (cnt_o == '0)); // R7
  end else begin : g_plain
    assign rvalid_o = !empty && !settle_q;
    assign rdata_o  = mem_rdata;
    assign push     = wvalid_i && wready_o;
    assign pop      = rvalid_o && rready_i;

    AST_PLAIN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o |-> (cnt_o != '0)); // R4
  end

  fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i, .rst_ni, .inc_i(push), .addr_o(waddr), .wrap_o(wwrap)
  );

  fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i, .rst_ni, .inc_i(pop), .addr_o(raddr), .wrap_o(rwrap)
  );

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i, .we_i(push), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  fifo_status #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_status (
    .waddr_i(waddr), .wwrap_i(wwrap), .raddr_i(raddr), .rwrap_i(rwrap),
    .empty_o(empty), .full_o(full), .cnt_o(cnt_o)
  );

  AST_SETTLE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_q |-> (!rvalid_o && !wready_o)); // R2
  AST_FULL_NO_WREADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CW'(DEPTH)) |-> !wready_o); // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH)); // R9
  AST_PUSHPOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0 && cnt_o != CW'(DEPTH) && wvalid_i && wready_o && rvalid_o && rready_i)
    |=> (cnt_o == $past(cnt_o))); // R8
  AST_STALL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wready_o && !(rvalid_o && rready_i)) |=> $stable(cnt_o)); // R10
endmodule

// File: tb/sync_fifo_pt_bench.sv
module sync_fifo_pt_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wv, rr, wr, rv;
  logic [7:0] wd, rd;
  logic [2:0] cnt;

  logic       np_wv, np_rr, np_wr, np_rv;
  logic [7:0] np_wd, np_rd;
  logic [1:0] np_cnt;

  sync_fifo_pt #(.WIDTH(W), .DEPTH(4), .PASS_THRU(1'b1)) u_sync_fifo_pt (
    .clk_i(clk), .rst_ni(rst_n), .wvalid_i(wv), .wready_o(wr), .wdata_i(wd),
    .rvalid_o(rv), .rready_i(rr), .rdata_o(rd), .cnt_o(cnt)
  );

  sync_fifo_pt #(.WIDTH(W), .DEPTH(2), .PASS_THRU(1'b0)) u_sync_fifo_pt_np (
    .clk_i(clk), .rst_ni(rst_n), .wvalid_i(np_wv), .wready_o(np_wr), .wdata_i(np_wd),
    .rvalid_o(np_rv), .rready_i(np_rr), .rdata_o(np_rd), .cnt_o(np_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic       w;
    logic [7:0] wd;
    logic       r;
    logic       rv;
    logic [7:0] rd;
    logic       wr;
    logic [2:0] cnt;
  } vec_t;

  // Inputs for one cycle and the outputs expected in that cycle (cnt before the edge).
  localparam vec_t VECS [12] = '{
    '{1'b1, 8'hA0, 1'b1, 1'b1, 8'hA0, 1'b1, 3'd0},
    '{1'b1, 8'hA1, 1'b0, 1'b1, 8'hA1, 1'b1, 3'd0},
    '{1'b1, 8'hA2, 1'b0, 1'b1, 8'hA1, 1'b1, 3'd1},
    '{1'b1, 8'hA3, 1'b1, 1'b1, 8'hA1, 1'b1, 3'd2},
    '{1'b1, 8'hA4, 1'b0, 1'b1, 8'hA2, 1'b1, 3'd2},
    '{1'b1, 8'hA5, 1'b0, 1'b1, 8'hA2, 1'b1, 3'd3},
    '{1'b1, 8'hA6, 1'b0, 1'b1, 8'hA2, 1'b0, 3'd4},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA2, 1'b0, 3'd4},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA3, 1'b1, 3'd3},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA4, 1'b1, 3'd2},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b1, 3'd1},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 3'd0}
  };

  task automatic np_step(input logic w, input logic [7:0] d, input logic r,
                         input logic e_rv, input logic [7:0] e_rd,
                         input logic e_wr, input int e_cnt, input string tag);
    @(negedge clk);
    np_wv = w; np_wd = d; np_rr = r;
    #2;
    chk({tag, " np rvalid"}, int'(np_rv), int'(e_rv));
    if (e_rv) chk({tag, " np rdata"}, int'(np_rd), int'(e_rd));
    chk({tag, " np wready"}, int'(np_wr), int'(e_wr));
    chk({tag, " np cnt"}, int'(np_cnt), e_cnt);
  endtask

  initial begin
    wv = 0; rr = 0; wd = '0;
    np_wv = 0; np_rr = 0; np_wd = '0;
    repeat (3) @(negedge clk);
    wv = 1'b1; wd = 8'h55;
    #2;
    chk("R1 cnt in reset", int'(cnt), 0);
    chk("R1 rvalid in reset", int'(rv), 0);

    // Release reset; first cycle is the settling cycle.
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R2 rvalid settle", int'(rv), 0);
    chk("R2 wready settle", int'(wr), 0);
    @(negedge clk);
    wv = 1'b0;
    #2;
    chk("R2 nothing stored", int'(cnt), 0);
    chk("R1 rvalid idle", int'(rv), 0);
    chk("R2 wready after", int'(wr), 1);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      wv = VECS[i].w; wd = VECS[i].wd; rr = VECS[i].r;
      #2;
      chk($sformatf("R6 rvalid v%0d", i), int'(rv), int'(VECS[i].rv));
      if (VECS[i].rv) chk($sformatf("R5 rdata v%0d", i), int'(rd), int'(VECS[i].rd));
      chk($sformatf("R3 wready v%0d", i), int'(wr), int'(VECS[i].wr));
      chk($sformatf("%s cnt v%0d", (i == 1) ? "R7" : (i == 4) ? "R8" : "R9", i),
          int'(cnt), int'(VECS[i].cnt));
    end

    // Plain variant: delayed visibility, full refusal, dropped write.
    np_step(1'b1, 8'hB0, 1'b0, 1'b0, 8'h00, 1'b1, 0, "R4");
    np_step(1'b1, 8'hB1, 1'b0, 1'b1, 8'hB0, 1'b1, 1, "R4");
    np_step(1'b1, 8'hB2, 1'b0, 1'b1, 8'hB0, 1'b0, 2, "R3");
    np_step(1'b0, 8'h00, 1'b1, 1'b1, 8'hB0, 1'b0, 2, "R10");
    np_step(1'b0, 8'h00, 1'b1, 1'b1, 8'hB1, 1'b1, 1, "R10");
    np_step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 0, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule